// File: doc/BRIEF.md
# Linked-List Descriptor Walker

This block follows a chain of transfer elements kept in a local descriptor memory and turns each valid element into one copy command for a data mover. Every element is six 32-bit words: a control word, a byte count, a 64-bit source address and a 64-bit destination address. The elements of a list sit back to back. A change bit in each control word says which pass of the list the element belongs to. The walker keeps an expected cycle bit and takes only elements whose change bit equals it.

A link element closes a list. It sends fetching to a new list start and inverts the expected cycle bit. An element whose change bit does not match is treated as stale. The walker then parks until software has refilled memory and rings the doorbell. Elements can request a local and/or a remote done interrupt. These interrupts are single-cycle pulses raised once the command for that element has been accepted. An abort input drops the walker back to idle at once.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset, cmd_valid, stalled, local_done, remote_done and abort_done are 0, and expect_cb is 1.
- R2: A doorbell pulse while idle starts fetching at word address list_base. Element word k (k = 0..5) is read from address base+k over a read port with one cycle of latency. The words are: 0 control, 1 byte count, 2 source low, 3 source high, 4 destination low, 5 destination high.
- R3: An element whose control bit 0 equals expect_cb and whose control bit 2 is clear drives cmd_valid with cmd_sar = {word3,word2}, cmd_dar = {word5,word4} and cmd_size = word1. These stay stable until cmd_ready is seen high.
- R4: The next element is not fetched until the current command is accepted. After a handshake cmd_valid drops, and the following element is read from the next six words, so commands come out in list order.
- R5: A matching element with control bit 2 set is a link. It issues no command, inverts expect_cb, and continues fetching at word address (word2 >> 2), taking word2 as a DWORD-aligned byte address.
- R6: An element whose control bit 0 differs from expect_cb raises stalled and issues no command. The walker stays there until a doorbell, which re-reads the same element address.
- R7: In the cycle after a command handshake, local_done pulses for one cycle if control bit 3 was set, and remote_done pulses for one cycle if control bit 4 was set. Neither pulses otherwise.
- R8: abort returns the walker to idle on the next edge: cmd_valid and stalled drop, and abort_done pulses for one cycle. abort takes priority over a handshake in the same cycle, which then raises no done pulse. expect_cb is kept, so a later doorbell restarts at list_base under the same cycle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| doorbell | input | 1 | Start (idle) or retry (stalled) pulse |
| abort | input | 1 | Return to idle |
| list_base | input | AW | Word address of the first element on start |
| desc_rd_en | output | 1 | Descriptor memory read strobe |
| desc_rd_addr | output | AW | Descriptor word address |
| desc_rd_data | input | 32 | Read data, one cycle after the strobe |
| cmd_valid | output | 1 | Copy command present |
| cmd_ready | input | 1 | Copy command accepted |
| cmd_sar | output | 64 | Source byte address |
| cmd_dar | output | 64 | Destination byte address |
| cmd_size | output | 32 | Byte count |
| stalled | output | 1 | Parked on a stale element |
| expect_cb | output | 1 | Current expected cycle bit |
| local_done | output | 1 | Local done interrupt pulse |
| remote_done | output | 1 | Remote done interrupt pulse |
| abort_done | output | 1 | Abort interrupt pulse |

## Verification
An abort and the acceptance of a command with both interrupt flags set can land on the same clock edge. Whichever wins decides whether done pulses appear. The bench provokes this by raising cmd_ready and abort together on an element carrying both flags. It then judges that only abort_done pulses, that the walker is idle and not stalled, and that a fresh doorbell reissues that same element under the unchanged cycle bit. Random lists with random backpressure, link hops and stale slots cover the ordinary walk.

// File: rtl/dcw_pkg.sv
// Shared types for the descriptor walker.
// Assumes six 32-bit words per element, control word first.
package dcw_pkg;
    localparam int DCW_WORDS = 6;
    localparam int CB_BIT    = 0;
    localparam int LINK_BIT  = 2;
    localparam int LIE_BIT   = 3;
    localparam int RIE_BIT   = 4;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] size;
        logic [31:0] sar_lo;
        logic [31:0] sar_hi;
        logic [31:0] dar_lo;
        logic [31:0] dar_hi;
    } dcw_elem_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DECODE, ST_ISSUE, ST_STALL
    } dcw_state_t;

    typedef enum logic [1:0] {
        K_XFER, K_LINK, K_STALE
    } dcw_kind_t;
endpackage

// File: rtl/dcw_fetch.sv
// Element fetcher: on go it reads DCW_WORDS consecutive words from the
// descriptor memory, starting at base, and captures them.
// Assumes read data arrives one cycle after the strobe. flush cancels a fetch.
module dcw_fetch
    import dcw_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          flush,
    input  logic [AW-1:0] base,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [31:0]   rd_data,
    output dcw_elem_t     elem,
    output logic          done
);
    localparam int IW = $clog2(DCW_WORDS + 1);
    localparam logic [IW-1:0] LAST = IW'(DCW_WORDS);

    logic          active;
    logic [IW-1:0] idx;
    logic [AW-1:0] base_q;
    logic [31:0]   word_q [DCW_WORDS];

    // Sequencer: word counter and latched base address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            base_q <= '0;
        end else if (flush) begin
            active <= 1'b0;
        end else if (go) begin
            active <= 1'b1;
            idx    <= '0;
            base_q <= base;
        end else if (active) begin
            idx <= idx + 1'b1;
            if (idx == LAST) active <= 1'b0;
        end
    end

    // Capture registers, one per element word.
    for (genvar k = 0; k < DCW_WORDS; k++) begin : g_cap
        always_ff @(posedge clk) begin
            if (!rst_n) word_q[k] <= '0;
            else if (active && idx == IW'(k + 1)) word_q[k] <= rd_data;
        end
    end

    // Read strobe, address and completion flag.
    always_comb begin
        rd_en   = active && (idx < LAST);
        rd_addr = base_q + AW'(idx);
        done    = active && (idx == LAST);
        elem    = '{ctrl: word_q[0], size: word_q[1], sar_lo: word_q[2],
                    sar_hi: word_q[3], dar_lo: word_q[4], dar_hi: word_q[5]};
    end

    // R2: the words of one element are read from consecutive addresses
    a_r2_contiguous_reads: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + AW'(1));
endmodule

// File: rtl/dcw_decode.sv
// Element classifier: stale (change bit mismatch), link, or plain transfer.
// Purely combinational; the change bit is checked before the link flag.
module dcw_decode
    import dcw_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          cb,
    input  logic          link,
    input  logic          exp_cb,
    input  logic [AW-1:0] next_word,
    output dcw_kind_t     kind,
    output logic [AW-1:0] link_ptr
);
    // Classification with the change bit taking priority.
    always_comb begin
        if (cb != exp_cb) kind = K_STALE;
        else if (link)    kind = K_LINK;
        else              kind = K_XFER;
        link_ptr = next_word;
    end
endmodule

// File: rtl/dcw_irq.sv
// Interrupt pulse generator: registers one-cycle done and abort pulses.
// Assumes hs already excludes a same-cycle abort.
module dcw_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic hs,
    input  logic lie,
    input  logic rie,
    input  logic abort,
    output logic local_done,
    output logic remote_done,
    output logic abort_done
);
    // Pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            local_done  <= 1'b0;
            remote_done <= 1'b0;
            abort_done  <= 1'b0;
        end else begin
            local_done  <= hs && lie;
            remote_done <= hs && rie;
            abort_done  <= abort;
        end
    end

    // R7: a done pulse lasts exactly one cycle
    a_r7_local_single: assert property (@(posedge clk) disable iff (!rst_n)
        local_done |=> !local_done);
    a_r7_remote_single: assert property (@(posedge clk) disable iff (!rst_n)
        remote_done |=> !remote_done);
endmodule

// File: rtl/desc_chain_walker.sv
// Descriptor walker top: walks a linked list of six-word elements, emits one
// copy command per valid element, follows link elements and parks on stale
// ones. Assumes a one-cycle-latency descriptor memory and a single doorbell
// for both start and retry.
module desc_chain_walker
    import dcw_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          doorbell,
    input  logic          abort,
    input  logic [AW-1:0] list_base,
    output logic          desc_rd_en,
    output logic [AW-1:0] desc_rd_addr,
    input  logic [31:0]   desc_rd_data,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [63:0]   cmd_sar,
    output logic [63:0]   cmd_dar,
    output logic [31:0]   cmd_size,
    output logic          stalled,
    output logic          expect_cb,
    output logic          local_done,
    output logic          remote_done,
    output logic          abort_done
);
    localparam logic [AW-1:0] STEP = AW'(DCW_WORDS);

    dcw_state_t    state, state_n;
    logic [AW-1:0] ptr, ptr_n;
    logic          go, fetch_done, hs;
    dcw_elem_t     elem;
    dcw_kind_t     kind;
    logic [AW-1:0] link_ptr;
    logic          unused_ctrl_bits;

    assign unused_ctrl_bits = ^{elem.ctrl[31:5], elem.ctrl[1]};

    dcw_fetch #(.AW(AW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .go(go), .flush(abort), .base(ptr_n),
        .rd_en(desc_rd_en), .rd_addr(desc_rd_addr), .rd_data(desc_rd_data),
        .elem(elem), .done(fetch_done)
    );

    dcw_decode #(.AW(AW)) u_decode (
        .cb(elem.ctrl[CB_BIT]), .link(elem.ctrl[LINK_BIT]), .exp_cb(expect_cb),
        .next_word(elem.sar_lo[AW+1:2]), .kind(kind), .link_ptr(link_ptr)
    );

    dcw_irq u_irq (
        .clk(clk), .rst_n(rst_n), .hs(hs),
        .lie(elem.ctrl[LIE_BIT]), .rie(elem.ctrl[RIE_BIT]), .abort(abort),
        .local_done(local_done), .remote_done(remote_done), .abort_done(abort_done)
    );

    // Next-state and next-fetch-address selection; abort overrides all.
    always_comb begin
        state_n = state;
        ptr_n   = ptr;
        go      = 1'b0;
        unique case (state)
            ST_IDLE: if (doorbell) begin
                go = 1'b1; ptr_n = list_base; state_n = ST_FETCH;
            end
            ST_FETCH: if (fetch_done) state_n = ST_DECODE;
            ST_DECODE: begin
                unique case (kind)
                    K_STALE: state_n = ST_STALL;
                    K_LINK: begin
                        go = 1'b1; ptr_n = link_ptr; state_n = ST_FETCH;
                    end
                    default: state_n = ST_ISSUE;
                endcase
            end
            ST_ISSUE: if (cmd_ready) begin
                go = 1'b1; ptr_n = ptr + STEP; state_n = ST_FETCH;
            end
            ST_STALL: if (doorbell) begin
                go = 1'b1; state_n = ST_FETCH;
            end
            default: state_n = ST_IDLE;
        endcase
        if (abort) begin
            state_n = ST_IDLE;
            go      = 1'b0;
        end
    end

    // State, element pointer and expected cycle bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ptr       <= '0;
            expect_cb <= 1'b1;
        end else begin
            state <= state_n;
            if (go) ptr <= ptr_n;
            if (!abort && state == ST_DECODE && kind == K_LINK)
                expect_cb <= ~expect_cb;
        end
    end

    // Command and status outputs.
    always_comb begin
        cmd_valid = (state == ST_ISSUE);
        stalled   = (state == ST_STALL);
        cmd_sar   = {elem.sar_hi, elem.sar_lo};
        cmd_dar   = {elem.dar_hi, elem.dar_lo};
        cmd_size  = elem.size;
        hs        = cmd_valid && cmd_ready && !abort;
    end

    // R3: a pending command holds its fields until accepted
    a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready && !abort |=>
        cmd_valid && $stable(cmd_sar) && $stable(cmd_dar) && $stable(cmd_size));
    // R4: no descriptor read while a command waits
    a_r4_no_read_during_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !desc_rd_en);
    // R5: the cycle bit only flips right after an element decode
    a_r5_cb_flip_at_decode: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(expect_cb) |-> $past(state == ST_DECODE));
    // R6: a stall persists until doorbell or abort
    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        stalled && !doorbell && !abort |=> stalled);
    // R7: done pulses only follow a command handshake
    a_r7_done_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (local_done || remote_done) |-> $past(cmd_valid && cmd_ready && !abort));
    // R8: abort clears command and stall and raises the abort pulse
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !cmd_valid && !stalled && abort_done && !local_done && !remote_done);
endmodule

// File: tb/desc_chain_walker_test.sv
module desc_chain_walker_test;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          doorbell = 1'b0;
    logic          abort = 1'b0;
    logic [AW-1:0] list_base = '0;
    logic          desc_rd_en;
    logic [AW-1:0] desc_rd_addr;
    logic [31:0]   desc_rd_data = '0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [63:0]   cmd_sar, cmd_dar;
    logic [31:0]   cmd_size;
    logic          stalled, expect_cb, local_done, remote_done, abort_done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [31:0] mem [1 << AW];

    always #2 clk = ~clk;

    desc_chain_walker #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .doorbell(doorbell), .abort(abort),
        .list_base(list_base), .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr),
        .desc_rd_data(desc_rd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_sar(cmd_sar), .cmd_dar(cmd_dar), .cmd_size(cmd_size),
        .stalled(stalled), .expect_cb(expect_cb), .local_done(local_done),
        .remote_done(remote_done), .abort_done(abort_done)
    );

    // Descriptor memory model with one cycle of read latency.
    always @(posedge clk) if (desc_rd_en) desc_rd_data <= mem[desc_rd_addr];

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_cmp = n_cmp + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(bit cb, bit lnk, bit lie, bit rie);
        return {27'd0, rie, lie, lnk, 1'b0, cb};
    endfunction

    task automatic put_elem(int a, bit cb, bit lie, bit rie, logic [63:0] s,
                            logic [63:0] d, logic [31:0] n);
        mem[a]   = ctrl_word(cb, 1'b0, lie, rie);
        mem[a+1] = n;
        mem[a+2] = s[31:0];
        mem[a+3] = s[63:32];
        mem[a+4] = d[31:0];
        mem[a+5] = d[63:32];
    endtask

    task automatic put_link(int a, bit cb, int target);
        mem[a]   = ctrl_word(cb, 1'b1, 1'b0, 1'b0);
        mem[a+1] = $urandom;
        mem[a+2] = 32'(target) << 2;
        mem[a+3] = $urandom;
        mem[a+4] = $urandom;
        mem[a+5] = $urandom;
    endtask

    task automatic ring();
        doorbell = 1'b1;
        @(negedge clk);
        doorbell = 1'b0;
    endtask

    // Wait for a command, apply random backpressure, accept it, check pulses.
    task automatic take_cmd(logic [63:0] s, logic [63:0] d, logic [31:0] n,
                            bit lie, bit rie);
        int hold;
        while (!cmd_valid) @(negedge clk);
        hold = $urandom % 3;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(cmd_valid && cmd_sar == s, "R3 hold", cmd_sar, s);
        end
        cmd_ready = 1'b1;
        chk(cmd_sar == s, "R3 sar", cmd_sar, s);
        chk(cmd_dar == d, "R3 dar", cmd_dar, d);
        chk(cmd_size == n, "R3 size", 64'(cmd_size), 64'(n));
        @(negedge clk);
        cmd_ready = 1'b0;
        chk(!cmd_valid, "R4 valid drops", 64'(cmd_valid), 64'd0);
        chk(local_done == lie, "R7 local", 64'(local_done), 64'(lie));
        chk(remote_done == rie, "R7 remote", 64'(remote_done), 64'(rie));
        @(negedge clk);
        chk(!local_done && !remote_done, "R7 single pulse",
            64'({local_done, remote_done}), 64'd0);
    endtask

    task automatic wait_stall(bit exp_cb);
        while (!stalled) @(negedge clk);
        chk(expect_cb == exp_cb, "R5 cycle bit", 64'(expect_cb), 64'(exp_cb));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(stalled && !cmd_valid, "R6 parked", 64'({stalled, cmd_valid}), 64'b10);
        end
    endtask

    initial begin
        int s_ptr;
        bit c;
        logic [63:0] es [5];
        logic [63:0] ed [5];
        logic [31:0] en [5];
        bit el [5];
        bit er [5];
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < (1 << AW); i++) mem[i] = 32'h0;

        // R1: reset values
        repeat (3) @(negedge clk);
        chk(!cmd_valid && !stalled && !local_done && !remote_done && !abort_done,
            "R1 outputs", 64'({cmd_valid, stalled, local_done, remote_done, abort_done}), 64'd0);
        chk(expect_cb == 1'b1, "R1 expect_cb", 64'(expect_cb), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed list: two elements, link, one element in the next pass, stale slot.
        put_elem(0, 1'b1, 1'b0, 1'b0, 64'h1111_2222_3333_4441, 64'hAAAA_BBBB_CCCC_DDD3, 32'd1);
        put_elem(6, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_0007, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF);
        put_link(12, 1'b1, 'h80);
        put_elem('h80, 1'b0, 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, 64'h0FED_CBA9_8765_4321, 32'd64);
        put_elem('h86, 1'b1, 1'b1, 1'b1, 64'h1, 64'h2, 32'd3);
        list_base = '0;
        ring();   // R2: start from list_base
        take_cmd(64'h1111_2222_3333_4441, 64'hAAAA_BBBB_CCCC_DDD3, 32'd1, 1'b0, 1'b0);
        take_cmd(64'h0000_0000_0000_0007, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
        take_cmd(64'h0123_4567_89AB_CDEF, 64'h0FED_CBA9_8765_4321, 32'd64, 1'b1, 1'b1);
        wait_stall(1'b0);   // R5 toggle, R6 stale element

        // Random passes: refill the stale slot, link to a new region, stall there.
        s_ptr = 'h86;
        c = 1'b0;
        for (int r = 0; r < 10; r++) begin
            int n;
            int region;
            n = 1 + ($urandom % 5);
            region = 'h100 + r * 64;
            for (int i = 0; i < n; i++) begin
                es[i] = {$urandom, $urandom};
                ed[i] = {$urandom, $urandom};
                en[i] = $urandom | 32'd1;
                el[i] = (i == n - 1) ? 1'($urandom) : 1'b0;
                er[i] = (i == n - 1) ? 1'($urandom) : 1'b0;
                put_elem(s_ptr + 6 * i, c, el[i], er[i], es[i], ed[i], en[i]);
            end
            put_link(s_ptr + 6 * n, c, region);
            put_elem(region, c, 1'b1, 1'b1, 64'h9, 64'h9, 32'd9);
            ring();   // R6: retry at the same address
            for (int i = 0; i < n; i++) take_cmd(es[i], ed[i], en[i], el[i], er[i]);
            wait_stall(~c);
            s_ptr = region;
            c = ~c;
        end

        // R8: abort in the same cycle as a handshake on a flagged element.
        put_elem(s_ptr, c, 1'b1, 1'b1, 64'hDEAD_BEEF_0000_0001, 64'hCAFE_F00D_0000_0002, 32'd77);
        put_elem(s_ptr + 6, ~c, 1'b0, 1'b0, 64'h0, 64'h0, 32'd5);
        ring();
        while (!cmd_valid) @(negedge clk);
        cmd_ready = 1'b1;
        abort = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        abort = 1'b0;
        chk(abort_done, "R8 abort pulse", 64'(abort_done), 64'd1);
        chk(!local_done && !remote_done, "R8 abort beats handshake",
            64'({local_done, remote_done}), 64'd0);
        chk(!cmd_valid && !stalled, "R8 idle", 64'({cmd_valid, stalled}), 64'd0);
        chk(expect_cb == c, "R8 cycle bit kept", 64'(expect_cb), 64'(c));
        @(negedge clk);
        chk(!abort_done, "R8 single pulse", 64'(abort_done), 64'd0);
        repeat (3) @(negedge clk);
        chk(!cmd_valid && !desc_rd_en, "R8 stays idle", 64'({cmd_valid, desc_rd_en}), 64'd0);
        list_base = AW'(s_ptr);
        ring();   // R2/R8: restart at list_base under the same cycle bit
        take_cmd(64'hDEAD_BEEF_0000_0001, 64'hCAFE_F00D_0000_0002, 32'd77, 1'b1, 1'b1);
        wait_stall(c);

        summary();
        $finish;
    end
endmodule